// File: doc/BRIEF.md
# Two-Channel Prescaled PWM Controller

This block is a register-mapped pulse-width modulator with two independent outputs. Software programs it through a simple 32-bit register port with separate write and read strobes and a byte address. One shared control word holds, for each channel, a 4-bit divider code, an enable bit, an active-level bit and a clock-run bit. Each channel also has its own timing word holding an 8-bit active count and an 8-bit period-minus-one count.

Each channel divides the system clock by a value chosen from a fixed table of non-power-of-two ratios, which includes a divide-by-one code and several unused codes. The divided ticks drive an 8-bit period counter. The output sits at the active level while the counter is below the active count. A new timing word is first held in a shadow copy and reaches the running counter only at the next period boundary. Until then a per-channel busy flag, readable in the control word, stays set.

The two divider scale factors are parameters. The defaults give ratios of 120 to 480 in the fine group and 12000 to 72000 in the coarse group. Smaller values keep the same code-to-ratio structure at a short simulation scale.

Top module: `pwm2ch_ctrl`

## Requirements
- R1: Accesses must use word-aligned byte addresses (address bits 1:0 = 0). Unaligned writes are dropped and unaligned reads return 0. Word 0 (address 0x0) is the control word. Channel n's timing word is at address 0x4 + 4*n. Channel n's control fields sit at a 15*n bit offset in the control word: divider code at bits 3:0, enable at bit 4, active level at bit 5, clock run at bit 6. Bits 7 to 9 of each channel's group read back as 0.
- R2: Divider codes 0, 1, 2, 3 and 4 give ratios FINE*2, FINE*3, FINE*4, FINE*6 and FINE*8. Codes 8, 9, 10, 11 and 12 give COARSE*2, COARSE*4, COARSE*6, COARSE*8 and COARSE*12. Code 15 divides by 1. Codes 5, 6, 7, 13 and 14 are invalid.
- R3: A timing word holds the active count D in bits 7:0 and the period-minus-one count P in bits 23:16. One output period lasts (P+1)*div clocks, and within it the output is at the active level for D*div clocks when D <= P.
- R4: With D = 0 the output never reaches the active level. With D >= P+1 it stays at the active level for the whole period.
- R5: With the active-level bit set to 1 the output is high while active and low otherwise. With the bit at 0 the output is inverted: low while active, high while inactive.
- R6: A channel runs only when enable and clock run are both 1 and its code is valid. Otherwise its output is held at the inactive level (the complement of the active-level bit).
- R7: A write to a channel's timing word sets that channel's busy flag at control bit 28+n. The shadow value moves into use at the next period boundary, or one clock later if the channel's enable is 0, and the flag clears at the same moment.
- R8: A timing-word write to a channel whose busy flag is set is dropped. The stored shadow value is unchanged.
- R9: Reads are registered, so reg_rdata is valid the clock after reg_rd. A timing-word read returns the shadow value with D in bits 7:0, P in bits 23:16 and all other bits 0.
- R10: After reset, the control word and both timing words read 0, both busy flags are 0, and both outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pwm_o | output | 2 | Channel outputs, bit n for channel n |

## Verification
The bench builds the block with FINE = 1 and COARSE = 2. Every valid code then divides by 1 to 24 clocks, so every valid code can be swept on both channels within a short run. For each code it tries period counts of 1, 3, 6 and 10 ticks, with active counts at zero, one, the last in-period value, exactly full and far above full, under both polarities. With these settings a period is at most a few hundred clocks long, which also lets the bench wait out a pending shadow load and check both when the busy flag clears and which value took effect.

// File: rtl/pwm2ch_pkg.sv
package pwm2ch_pkg;
  localparam int NCH       = 2;
  localparam int CH_STRIDE = 15;
  localparam int BUSY_BASE = 28;
  localparam int CNT_W     = 8;

  typedef struct packed {
    logic [3:0] code;
    logic       en;
    logic       act;
    logic       gate;
  } ch_ctl_t;

  // Ratio for a divider code; 0 marks an invalid code.
  function automatic int unsigned div_of(input logic [3:0] code,
                                         input int unsigned fine,
                                         input int unsigned coarse);
    case (code)
      4'd0:    return fine * 2;
      4'd1:    return fine * 3;
      4'd2:    return fine * 4;
      4'd3:    return fine * 6;
      4'd4:    return fine * 8;
      4'd8:    return coarse * 2;
      4'd9:    return coarse * 4;
      4'd10:   return coarse * 6;
      4'd11:   return coarse * 8;
      4'd12:   return coarse * 12;
      4'd15:   return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/pwm2ch_prescaler.sv
module pwm2ch_prescaler #(
  parameter int FINE_UNIT   = 60,
  parameter int COARSE_UNIT = 6000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] code,
  input  logic       run,
  input  logic       clear,
  output logic       tick,
  output logic       code_ok
);
  localparam int MAX_DIV = (COARSE_UNIT * 12 > FINE_UNIT * 8) ? COARSE_UNIT * 12 : FINE_UNIT * 8;
  localparam int DIV_W   = $clog2(MAX_DIV + 1);

  logic [DIV_W-1:0] div_val;
  logic [DIV_W-1:0] cnt_q;

  assign div_val = DIV_W'(pwm2ch_pkg::div_of(code, FINE_UNIT, COARSE_UNIT));
  assign code_ok = (div_val != '0);
  // >= keeps the count bounded if the code is changed to a smaller ratio
  assign tick    = run && code_ok && (cnt_q >= div_val - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (run && code_ok) begin
      cnt_q <= tick ? '0 : cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/pwm2ch_channel.sv
module pwm2ch_channel #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             act_lvl,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wr_duty,
  input  logic [CNT_W-1:0] wr_prd,
  output logic             busy,
  output logic [CNT_W-1:0] sh_duty,
  output logic [CNT_W-1:0] sh_prd,
  output logic [CNT_W-1:0] cur_duty,
  output logic [CNT_W-1:0] cur_prd,
  output logic             pwm
);
  logic [CNT_W-1:0] cyc_q;
  logic             boundary;
  logic             load;

  assign boundary = tick && (cyc_q >= cur_prd);
  assign load     = busy && (!en || boundary);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q    <= '0;
      sh_duty  <= '0;
      sh_prd   <= '0;
      cur_duty <= '0;
      cur_prd  <= '0;
      busy     <= 1'b0;
      pwm      <= 1'b1;
    end else begin
      if (!en) begin
        cyc_q <= '0;
      end else if (boundary) begin
        cyc_q <= '0;
      end else if (tick) begin
        cyc_q <= cyc_q + CNT_W'(1);
      end

      if (wr && !busy) begin
        sh_duty <= wr_duty;
        sh_prd  <= wr_prd;
        busy    <= 1'b1;
      end else if (load) begin
        cur_duty <= sh_duty;
        cur_prd  <= sh_prd;
        busy     <= 1'b0;
      end

      pwm <= (run && (cyc_q < cur_duty)) ? act_lvl : !act_lvl;
    end
  end
endmodule

// File: rtl/pwm2ch_ctrl.sv
module pwm2ch_ctrl
  import pwm2ch_pkg::*;
#(
  parameter int FINE_UNIT   = 60,
  parameter int COARSE_UNIT = 6000,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCH-1:0]    pwm_o
);
  localparam int IDX_W = ADDR_W - 2;

  ch_ctl_t [NCH-1:0]            ctl_q;
  logic [NCH-1:0]               ch_en, ch_act, ch_gate, ch_run;
  logic [NCH-1:0]               tick, code_ok, busy, wr_prd;
  logic [NCH-1:0][CNT_W-1:0]    sh_duty, sh_prd, cur_duty, cur_prd;
  logic [IDX_W-1:0]             idx;
  logic                         aligned, wr_hit, wr_ctl;
  logic [31:0]                  ctl_rd, rd_mux;
  logic                         unused_wbits;

  assign idx     = reg_addr[ADDR_W-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign wr_hit  = reg_wr && aligned;
  assign wr_ctl  = wr_hit && (idx == '0);
  assign unused_wbits = ^{reg_wdata[31:24], reg_wdata[14:8]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wr_ctl) begin
      for (int n = 0; n < NCH; n++) begin
        ctl_q[n].code <= reg_wdata[n*CH_STRIDE +: 4];
        ctl_q[n].en   <= reg_wdata[n*CH_STRIDE + 4];
        ctl_q[n].act  <= reg_wdata[n*CH_STRIDE + 5];
        ctl_q[n].gate <= reg_wdata[n*CH_STRIDE + 6];
      end
    end
  end

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign ch_en[n]   = ctl_q[n].en;
    assign ch_act[n]  = ctl_q[n].act;
    assign ch_gate[n] = ctl_q[n].gate;
    assign ch_run[n]  = ch_en[n] && ch_gate[n] && code_ok[n];
    assign wr_prd[n]  = wr_hit && (idx == IDX_W'(n + 1));

    pwm2ch_prescaler #(
      .FINE_UNIT  (FINE_UNIT),
      .COARSE_UNIT(COARSE_UNIT)
    ) u_pre (
      .clk    (clk),
      .rst    (rst),
      .code   (ctl_q[n].code),
      .run    (ch_en[n] && ch_gate[n]),
      .clear  (!ch_en[n]),
      .tick   (tick[n]),
      .code_ok(code_ok[n])
    );

    pwm2ch_channel #(
      .CNT_W(CNT_W)
    ) u_chan (
      .clk     (clk),
      .rst     (rst),
      .en      (ch_en[n]),
      .run     (ch_run[n]),
      .act_lvl (ch_act[n]),
      .tick    (tick[n]),
      .wr      (wr_prd[n]),
      .wr_duty (reg_wdata[CNT_W-1:0]),
      .wr_prd  (reg_wdata[16 +: CNT_W]),
      .busy    (busy[n]),
      .sh_duty (sh_duty[n]),
      .sh_prd  (sh_prd[n]),
      .cur_duty(cur_duty[n]),
      .cur_prd (cur_prd[n]),
      .pwm     (pwm_o[n])
    );
  end

  always_comb begin
    ctl_rd = '0;
    for (int n = 0; n < NCH; n++) begin
      ctl_rd[n*CH_STRIDE +: 4]  = ctl_q[n].code;
      ctl_rd[n*CH_STRIDE + 4]   = ctl_q[n].en;
      ctl_rd[n*CH_STRIDE + 5]   = ctl_q[n].act;
      ctl_rd[n*CH_STRIDE + 6]   = ctl_q[n].gate;
      ctl_rd[BUSY_BASE + n]     = busy[n];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (idx == '0) begin
        rd_mux = ctl_rd;
      end
      for (int n = 0; n < NCH; n++) begin
        if (idx == IDX_W'(n + 1)) begin
          rd_mux = {8'h00, sh_prd[n], 8'h00, sh_duty[n]};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pwm2ch_sva.sv
module pwm2ch_sva
  import pwm2ch_pkg::*;
(
  input logic                      clk,
  input logic                      rst,
  input logic [NCH-1:0]            pwm_o,
  input logic [NCH-1:0]            ch_en,
  input logic [NCH-1:0]            ch_act,
  input logic [NCH-1:0]            ch_run,
  input logic [NCH-1:0]            ch_busy,
  input logic [NCH-1:0]            wr_prd,
  input logic [NCH-1:0][CNT_W-1:0] sh_duty,
  input logic [NCH-1:0][CNT_W-1:0] sh_prd,
  input logic [NCH-1:0][CNT_W-1:0] cur_duty,
  input logic [NCH-1:0][CNT_W-1:0] cur_prd
);
  for (genvar n = 0; n < NCH; n++) begin : g_chk
    // R6: a stopped channel shows the inactive level
    p_idle_level_r6: assert property (@(posedge clk) disable iff (rst)
      !ch_run[n] |=> (pwm_o[n] == !$past(ch_act[n])));

    // R4: zero active count never reaches the active level
    p_zero_duty_r4: assert property (@(posedge clk) disable iff (rst)
      (ch_run[n] && cur_duty[n] == '0) |=> (pwm_o[n] == !$past(ch_act[n])));

    // R4: active count beyond the period keeps the output active
    p_full_duty_r4: assert property (@(posedge clk) disable iff (rst)
      (ch_run[n] && cur_duty[n] > cur_prd[n]) |=> (pwm_o[n] == $past(ch_act[n])));

    // R8: a write while busy leaves the shadow untouched
    p_busy_write_dropped_r8: assert property (@(posedge clk) disable iff (rst)
      (ch_busy[n] && wr_prd[n]) |=> $stable({sh_prd[n], sh_duty[n]}));

    // R7: a disabled channel takes its pending value at once
    p_flag_drains_when_off_r7: assert property (@(posedge clk) disable iff (rst)
      (ch_busy[n] && !ch_en[n]) |=> !ch_busy[n]);
  end
endmodule

bind pwm2ch_ctrl pwm2ch_sva u_sva (
  .clk     (clk),
  .rst     (rst),
  .pwm_o   (pwm_o),
  .ch_en   (ch_en),
  .ch_act  (ch_act),
  .ch_run  (ch_run),
  .ch_busy (busy),
  .wr_prd  (wr_prd),
  .sh_duty (sh_duty),
  .sh_prd  (sh_prd),
  .cur_duty(cur_duty),
  .cur_prd (cur_prd)
);

// File: tb/pwm2ch_ctrl_tb.sv
module pwm2ch_ctrl_tb;
  localparam int FINE   = 1;
  localparam int COARSE = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  pwm_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] ctl_m = '0;

  always #5 clk = ~clk;

  pwm2ch_ctrl #(.FINE_UNIT(FINE), .COARSE_UNIT(COARSE), .ADDR_W(4)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_o(pwm_o)
  );

  function automatic int exp_div(int code);
    case (code)
      0: return FINE * 2;   1: return FINE * 3;   2: return FINE * 4;
      3: return FINE * 6;   4: return FINE * 8;
      8: return COARSE * 2; 9: return COARSE * 4; 10: return COARSE * 6;
      11: return COARSE * 8; 12: return COARSE * 12;
      15: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(addr); reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int addr, output logic [31:0] data);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'(addr);
    @(negedge clk);
    reg_rd = 1'b0;
    data = reg_rdata;
  endtask

  task automatic set_ch(int ch, int code, bit en, bit act, bit gate);
    ctl_m[ch*15 +: 7] = {gate, act, en, 4'(code)};
    wr(0, ctl_m);
  endtask

  task automatic measure(int ch, int ncyc, output int high);
    high = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (pwm_o[ch]) high++;
    end
  endtask

  task automatic run_case(int ch, int code, int prd, int duty, bit act);
    logic [31:0] v;
    int dv, total, on, hi, exp;
    string tag;
    set_ch(ch, code, 1'b0, act, 1'b0);
    wr(4 + 4*ch, (32'(prd) << 16) | 32'(duty));
    rd(4 + 4*ch, v);
    check(v == ((32'(prd) << 16) | 32'(duty)), "R9 timing readback", v, (32'(prd) << 16) | 32'(duty));
    set_ch(ch, code, 1'b1, act, 1'b1);
    repeat (3) @(negedge clk);
    dv = exp_div(code);
    if (dv == 0) begin
      measure(ch, 40, hi);
      exp = act ? 0 : 40;
      check(hi == exp, $sformatf("R6 R2 invalid code %0d ch%0d", code, ch), hi, exp);
    end else begin
      total = 2 * (prd + 1) * dv;
      on = 2 * ((duty < prd + 1) ? duty : prd + 1) * dv;
      exp = act ? on : total - on;
      measure(ch, total, hi);
      if (duty == 0 || duty > prd) tag = "R4";
      else tag = "R3";
      check(hi == exp, $sformatf("%s R2 R5 ch%0d code=%0d P=%0d D=%0d act=%0d",
                                 tag, ch, code, prd, duty, act), hi, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int hi;
    int prds[4]  = '{0, 2, 5, 9};
    int codes[16] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    check(pwm_o == 2'b11, "R10 outputs after reset", pwm_o, 2'b11);
    rd(0, v); check(v == 32'h0, "R10 control word", v, 0);
    rd(4, v); check(v == 32'h0, "R10 timing ch0", v, 0);
    rd(8, v); check(v == 32'h0, "R10 timing ch1", v, 0);

    // R1 field layout and unused bits
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); check(v == 32'h003F_807F, "R1 control readback", v, 32'h003F_807F);
    rd(1, v); check(v == 32'h0, "R1 unaligned read", v, 0);
    wr(0, 32'h0);
    ctl_m = '0;
    repeat (2) @(negedge clk);
    wr(5, 32'h0003_0002);
    rd(4, v); check(v == 32'h0, "R1 unaligned write dropped", v, 0);
    rd(0, v); check(v == 32'h0, "R1 R7 no busy after dropped write", v, 0);

    // R2 R3 R4 R5: sweep codes, periods, duties on both channels
    for (int ch = 0; ch < 2; ch++) begin
      for (int ci = 0; ci < 16; ci++) begin
        if (exp_div(codes[ci]) == 0) begin
          run_case(ch, codes[ci], 3, 2, 1'b1);
        end else begin
          for (int pi = 0; pi < 4; pi++) begin
            int dl[5];
            dl = '{0, 1, prds[pi], prds[pi] + 1, 255};
            for (int di = 0; di < 5; di++)
              run_case(ch, codes[ci], prds[pi], dl[di], 1'((codes[ci] + dl[di] + pi) % 2));
          end
        end
      end
      set_ch(ch, 15, 1'b0, 1'b0, 1'b0);
    end

    // R6: clock run clear, or enable clear, keeps inactive level
    wr(4, 32'h0003_0002);
    set_ch(0, 15, 1'b1, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    measure(0, 30, hi); check(hi == 0, "R6 run bit clear", hi, 0);
    set_ch(0, 15, 1'b0, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    measure(0, 30, hi); check(hi == 0, "R6 enable clear", hi, 0);
    set_ch(0, 15, 1'b0, 1'b0, 1'b0);

    // R7 R8: shadow loading and busy flag on channel 1
    wr(8, 32'h00C7_0005);               // P=199 D=5
    set_ch(1, 15, 1'b1, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    wr(8, 32'h0009_0004);               // P=9 D=4
    rd(0, v); check(v[29] == 1'b1, "R7 busy set after write", v[29], 1);
    check(v[28] == 1'b0, "R7 other channel flag clear", v[28], 0);
    wr(8, 32'h0007_0002);               // dropped
    rd(8, v); check(v == 32'h0009_0004, "R8 write while busy dropped", v, 32'h0009_0004);
    repeat (210) @(negedge clk);
    rd(0, v); check(v[29] == 1'b0, "R7 busy cleared at boundary", v[29], 0);
    repeat (2) @(negedge clk);
    measure(1, 20, hi); check(hi == 8, "R7 new timing in use", hi, 8);

    // R7: disabled channel loads at once
    wr(4, 32'h0004_0001);
    rd(0, v); check(v[28] == 1'b0, "R7 disabled channel loads at once", v[28], 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule